// File: doc/BRIEF.md
# Banked data memory address unit

This unit forms the 12-bit data-memory address for an 8-bit microcontroller core whose register file covers 4 KB, arranged as sixteen 256-byte banks. It does not hold the memory. It keeps the small set of address registers and, in the same cycle, turns the addressing fields of the current instruction into an effective address.

There are two ways to address. In direct mode the 8-bit file field of the instruction is the low byte. With the bank flag set, the high nibble comes from a 4-bit bank register. With the flag clear, a fixed window applies: the lower half of bank 0 and the upper half of bank 15 form one virtual bank, whatever the bank register holds. In indirect mode, one of three 12-bit pointers supplies the address. That pointer may be stepped by one at the clock edge, so a loop can walk through consecutive bytes.

Software loads the bank register and the pointer bytes through one byte-wide write port. The current values are always visible on the outputs.

Top module: `dmem_addr_unit`

## Requirements
- R1: After a synchronous reset, the bank register and all three pointers read 0.
- R2: When `ind_en`=0 and `banked`=1, `eff_addr` equals {bank register, `file_fld`} in the same cycle. For example, bank 2 with file field 0x82 gives 0x282.
- R3: When `ind_en`=0 and `banked`=0, a file field 0x00–0x7F gives address 0x000–0x07F and a file field 0x80–0xFF gives 0xF80–0xFFF. The bank register has no effect in this case.
- R4: A write with `wr_sel`=0 stores `wr_data[3:0]` in the bank register. The upper four data bits are dropped. The new value is visible after the clock edge.
- R5: Pointer bytes are written through `wr_sel`: 1/2 select the low/high byte of pointer 0, 3/4 those of pointer 1, and 5/6 those of pointer 2. A low-byte write sets pointer bits [7:0]. A high-byte write stores only `wr_data[3:0]` as pointer bits [11:8]. The value 7 writes nothing.
- R6: When `ind_en`=1 and `ind_ptr` is 0, 1 or 2, `eff_addr` equals that pointer in the same cycle. `banked`, `file_fld` and the bank register are ignored.
- R7: When `ind_en`=1 and `post_inc`=1 at a clock edge, the selected pointer grows by one. The carry passes from bit 7 into bit 8, and 0xFFF wraps to 0x000. The other pointers do not change.
- R8: If the same edge both writes a byte of the pointer being incremented and increments it, the write takes effect and the increment is dropped.
- R9: `ind_ptr`=3 with `ind_en`=1 gives `eff_addr`=0x000 and increments no pointer.
- R10: `post_inc` with `ind_en`=0 changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| file_fld | input | 8 | File field of the instruction |
| banked | input | 1 | 1: use the bank register, 0: use the virtual access bank |
| ind_en | input | 1 | Selects indirect addressing |
| ind_ptr | input | 2 | Pointer index for indirect addressing |
| post_inc | input | 1 | Step the selected pointer at the clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| eff_addr | output | 12 | Effective data address |
| bank_q | output | 4 | Bank register |
| ptr0_q | output | 12 | Pointer 0 |
| ptr1_q | output | 12 | Pointer 1 |
| ptr2_q | output | 12 | Pointer 2 |

## Verification
The hardest cases to reach from the ports are the carry from the low byte into the high nibble and the wrap from 0xFFF. Both happen only on particular pointer values that lie far apart. The bench therefore loads each pointer byte by byte to one step below each boundary and then issues single increments. A second hard case is a byte write and an increment that hit the same pointer on the same edge. The bench drives both in one cycle, with a write value that differs from the incremented value, so the result shows which one won.

// File: rtl/dmem_addr_pkg.sv
package dmem_addr_pkg;

    localparam int ADDR_W  = 12;
    localparam int FILE_W  = 8;
    localparam int BANK_W  = ADDR_W - FILE_W;
    localparam int NUM_PTR = 3;
    localparam int PSEL_W  = 2;
    localparam int WSEL_W  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [FILE_W-1:0] file_t;

    typedef enum logic [WSEL_W-1:0] {
        WR_BANK = 3'd0,
        WR_P0LO = 3'd1,
        WR_P0HI = 3'd2,
        WR_P1LO = 3'd3,
        WR_P1HI = 3'd4,
        WR_P2LO = 3'd5,
        WR_P2HI = 3'd6,
        WR_NONE = 3'd7
    } wr_target_e;

    typedef struct packed {
        logic               ind;
        logic [PSEL_W-1:0]  psel;
        logic               banked;
        file_t              f;
    } addr_req_t;

    function automatic logic [WSEL_W-1:0] lo_code(input int idx);
        return WSEL_W'(1 + 2 * idx);
    endfunction

    function automatic logic [WSEL_W-1:0] hi_code(input int idx);
        return WSEL_W'(2 + 2 * idx);
    endfunction

    // Virtual access bank: low half maps to bank 0, high half to the top bank
    function automatic addr_t access_map(input file_t f);
        return f[FILE_W-1] ? {{BANK_W{1'b1}}, f} : {{BANK_W{1'b0}}, f};
    endfunction

endpackage

// File: rtl/dmem_bank_reg.sv
module dmem_bank_reg
    import dmem_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  bank_t din,
    output bank_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/dmem_ptr_reg.sv
module dmem_ptr_reg
    import dmem_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_lo,
    input  logic  wr_hi,
    input  file_t wr_data,
    input  logic  inc,
    output addr_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_lo)
            q <= {q[ADDR_W-1:FILE_W], wr_data};
        else if (wr_hi)
            q <= {wr_data[BANK_W-1:0], q[FILE_W-1:0]};
        else if (inc)
            q <= q + addr_t'(1);
    end
endmodule

// File: rtl/dmem_addr_mux.sv
module dmem_addr_mux
    import dmem_addr_pkg::*;
(
    input  addr_req_t               req,
    input  bank_t                   bank,
    input  addr_t [NUM_PTR-1:0]     ptrs,
    output addr_t                   addr
);
    always_comb begin
        addr = '0;
        if (req.ind) begin
            for (int i = 0; i < NUM_PTR; i++)
                if (req.psel == PSEL_W'(i))
                    addr = ptrs[i];
        end else if (req.banked) begin
            addr = {bank, req.f};
        end else begin
            addr = access_map(req.f);
        end
    end
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
    import dmem_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  file_fld,
    input  logic        banked,
    input  logic        ind_en,
    input  logic [1:0]  ind_ptr,
    input  logic        post_inc,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [11:0] eff_addr,
    output logic [3:0]  bank_q,
    output logic [11:0] ptr0_q,
    output logic [11:0] ptr1_q,
    output logic [11:0] ptr2_q
);
    addr_t [NUM_PTR-1:0] ptrs;
    addr_req_t           req;
    bank_t               bank;

    dmem_bank_reg u_bank (
        .clk  (clk),
        .rst  (rst),
        .load (wr_en && wr_sel == WR_BANK),
        .din  (wr_data[BANK_W-1:0]),
        .q    (bank)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic step;
        assign step = ind_en && post_inc && (ind_ptr == PSEL_W'(g));
        dmem_ptr_reg u_ptr (
            .clk     (clk),
            .rst     (rst),
            .wr_lo   (wr_en && wr_sel == lo_code(g)),
            .wr_hi   (wr_en && wr_sel == hi_code(g)),
            .wr_data (wr_data),
            .inc     (step),
            .q       (ptrs[g])
        );
    end

    assign req = '{ind: ind_en, psel: ind_ptr, banked: banked, f: file_fld};

    dmem_addr_mux u_mux (
        .req  (req),
        .bank (bank),
        .ptrs (ptrs),
        .addr (eff_addr)
    );

    assign bank_q = bank;
    assign ptr0_q = ptrs[0];
    assign ptr1_q = ptrs[1];
    assign ptr2_q = ptrs[2];
endmodule

// File: rtl/dmem_addr_chk.sv
module dmem_addr_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  file_fld,
    input logic        banked,
    input logic        ind_en,
    input logic [1:0]  ind_ptr,
    input logic        post_inc,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [11:0] eff_addr,
    input logic [3:0]  bank_q,
    input logic [11:0] ptr0_q,
    input logic [11:0] ptr1_q,
    input logic [11:0] ptr2_q
);
    assert_direct_bank_R2: assert property (@(posedge clk) disable iff (rst)
        (!ind_en && banked) |-> eff_addr == {bank_q, file_fld});

    assert_access_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!ind_en && !banked && !file_fld[7]) |-> eff_addr[11:8] == 4'h0);

    assert_access_high_R3: assert property (@(posedge clk) disable iff (rst)
        (!ind_en && !banked && file_fld[7]) |-> eff_addr[11:8] == 4'hF);

    assert_indirect_p1_R6: assert property (@(posedge clk) disable iff (rst)
        (ind_en && ind_ptr == 2'd1) |-> eff_addr == ptr1_q);

    assert_step_p0_R7: assert property (@(posedge clk) disable iff (rst)
        (ind_en && post_inc && ind_ptr == 2'd0 && !(wr_en && (wr_sel == 3'd1 || wr_sel == 3'd2)))
        |=> ptr0_q == $past(ptr0_q) + 12'd1);

    assert_bad_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (ind_en && ind_ptr == 2'd3) |-> eff_addr == 12'h000);

    assert_no_step_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ind_en) |=> $stable(ptr0_q) && $stable(ptr1_q) && $stable(ptr2_q) && $stable(bank_q));
endmodule

bind dmem_addr_unit dmem_addr_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .file_fld (file_fld),
    .banked   (banked),
    .ind_en   (ind_en),
    .ind_ptr  (ind_ptr),
    .post_inc (post_inc),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .eff_addr (eff_addr),
    .bank_q   (bank_q),
    .ptr0_q   (ptr0_q),
    .ptr1_q   (ptr1_q),
    .ptr2_q   (ptr2_q)
);

// File: tb/test_dmem_addr_unit.sv
`timescale 1ns/1ps
module test_dmem_addr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  file_fld;
    logic        banked;
    logic        ind_en;
    logic [1:0]  ind_ptr;
    logic        post_inc;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [7:0]  wr_data;
    logic [11:0] eff_addr;
    logic [3:0]  bank_q;
    logic [11:0] ptr0_q, ptr1_q, ptr2_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dmem_addr_unit i_dmem_addr_unit (
        .clk(clk), .rst(rst), .file_fld(file_fld), .banked(banked),
        .ind_en(ind_en), .ind_ptr(ind_ptr), .post_inc(post_inc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .eff_addr(eff_addr), .bank_q(bank_q),
        .ptr0_q(ptr0_q), .ptr1_q(ptr1_q), .ptr2_q(ptr2_q)
    );

    // {bank, banked, file, expected address}
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {4'h2, 1'b1, 8'h82, 12'h282},
        {4'hF, 1'b1, 8'h00, 12'hF00},
        {4'h0, 1'b1, 8'hFF, 12'h0FF},
        {4'h7, 1'b1, 8'h80, 12'h780},
        {4'hA, 1'b0, 8'h7F, 12'h07F},
        {4'hA, 1'b0, 8'h80, 12'hF80},
        {4'h5, 1'b0, 8'h00, 12'h000},
        {4'h5, 1'b0, 8'hFF, 12'hFFF},
        {4'hC, 1'b0, 8'h3C, 12'h03C}
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0; wr_sel = 3'd7;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; file_fld = '0; banked = 1'b0; ind_en = 1'b0; ind_ptr = '0;
        post_inc = 1'b0; wr_en = 1'b0; wr_sel = 3'd7; wr_data = '0;
        repeat (3) step();
        rst = 1'b0;
        #1;
        check("R1 bank", {8'h0, bank_q}, 12'h000);
        check("R1 ptr0", ptr0_q, 12'h000);
        check("R1 ptr1", ptr1_q, 12'h000);
        check("R1 ptr2", ptr2_q, 12'h000);

        // Table walk: R2 banked direct, R3 access bank
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, {4'h9, VEC[i][24:21]});
            banked = VEC[i][20];
            file_fld = VEC[i][19:12];
            #1;
            check(VEC[i][20] ? "R2 direct" : "R3 access", eff_addr, VEC[i][11:0]);
        end

        // R4 upper bits of bank write dropped
        wr(3'd0, 8'hF7);
        check("R4 bank", {8'h0, bank_q}, 12'h007);

        // R5 pointer byte writes
        wr(3'd1, 8'hFE);
        wr(3'd2, 8'hA3);
        check("R5 ptr0", ptr0_q, 12'h3FE);
        wr(3'd7, 8'h55);
        check("R5 none", ptr0_q, 12'h3FE);

        // R6 indirect ignores bank and file
        banked = 1'b1; file_fld = 8'h12; ind_en = 1'b1; ind_ptr = 2'd0;
        #1;
        check("R6 indirect", eff_addr, 12'h3FE);

        // R7 increment with carry into high nibble
        post_inc = 1'b1;
        step();
        check("R7 inc", ptr0_q, 12'h3FF);
        step();
        check("R7 carry", ptr0_q, 12'h400);
        post_inc = 1'b0;

        // R7 wrap on pointer 1
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'h0F);
        check("R5 ptr1", ptr1_q, 12'hFFF);
        ind_ptr = 2'd1; post_inc = 1'b1;
        step();
        post_inc = 1'b0;
        check("R7 wrap", ptr1_q, 12'h000);
        check("R7 others", ptr0_q, 12'h400);

        // R8 write beats increment
        wr(3'd5, 8'h55);
        ind_ptr = 2'd2; post_inc = 1'b1;
        wr(3'd5, 8'h10);
        post_inc = 1'b0;
        check("R8 write wins", ptr2_q, 12'h010);

        // R9 invalid pointer index
        ind_ptr = 2'd3;
        #1;
        check("R9 addr", eff_addr, 12'h000);
        post_inc = 1'b1;
        step();
        post_inc = 1'b0;
        check("R9 p0", ptr0_q, 12'h400);
        check("R9 p2", ptr2_q, 12'h010);

        // R10 increment without indirect mode
        ind_en = 1'b0; ind_ptr = 2'd0; post_inc = 1'b1;
        step();
        post_inc = 1'b0;
        check("R10 p0", ptr0_q, 12'h400);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule